// File: doc/BRIEF.md
# Partitioned 8x16 SIMD Multiplier

This block multiplies four 8-bit values by four signed 16-bit values in parallel and returns four 16-bit lane results packed into one 64-bit word. Each lane keeps the middle sixteen bits of its product after a fixed-point rounding step. The result is an 8-bit fraction scaled by a 16-bit quantity, as used in pixel blending and gain stages. A 2-bit selector picks how the bytes and the 16-bit multipliers are taken from the two 64-bit operands. It can use packed unsigned bytes, a broadcast scalar, or the upper or lower byte of each 16-bit word.

An operation is presented with `in_valid` high for one cycle. Its packed result appears on `out_data` with `out_valid` high two cycles later. A new operation may start every cycle. Between results, the output keeps the last value it produced.

Top module: `simd_mul8x16`

## Requirements
- R1: Lane n (n = 0..3) is written to `out_data[16n+15:16n]`. It depends only on that lane's selected byte and multiplier, so four different lane inputs give four independent results.
- R2: Each lane result is the low 16 bits of (m × w + 128) shifted right arithmetically by 8, where m is the selected byte and w the signed multiplier. The 128 is added for every product. For m = 1, w = 0x0080, 0x007F, 0xFF80 and 0xFF7F give 0x0001, 0x0000, 0x0000 and 0xFFFF.
- R3: With `in_mode` = 0, lane n uses the unsigned byte `in_opa[8n+7:8n]` and the signed word `in_opb[16n+15:16n]`.
- R4: With `in_mode` = 1, lane n uses the unsigned byte `in_opa[8n+7:8n]` and the signed scalar `in_opb[15:0]` shared by all lanes. `in_opb[63:16]` has no effect, and a scalar of 0x0100 returns each byte zero-extended.
- R5: With `in_mode` = 2, lane n uses the signed byte `in_opa[16n+15:16n+8]` and the signed word `in_opb[16n+15:16n]`.
- R6: With `in_mode` = 3, lane n uses the unsigned byte `in_opa[16n+7:16n]` and the signed word `in_opb[16n+15:16n]`.
- R7: In modes 0 and 1, `in_opa[63:32]` has no effect on the result.
- R8: `out_valid` equals `in_valid` from two clock cycles earlier. Back-to-back operations give back-to-back results in the same order.
- R9: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero at the next edge and discards operations in flight. If any 16-bit multiplier is zero, that lane's result is zero.
- R10: While `out_valid` is low, `out_data` keeps its last value.
- R11: Extreme operands do not overflow before rounding: 0xFF × 0x8000 in mode 3 gives 0x8080, 0x80 × 0x8000 in mode 2 gives 0x4000, and 0xFF × 0x7FFF in mode 0 gives 0x7F7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_mode | input | 2 | Operand selection: 0 packed bytes, 1 broadcast scalar, 2 signed upper byte, 3 unsigned lower byte |
| in_opa | input | 64 | Source of the 8-bit values |
| in_opb | input | 64 | Source of the signed 16-bit multipliers |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 64 | Four packed 16-bit lane results |

## Verification
The risky internal state is the first pipeline stage, which holds the selected bytes and multipliers. A wrong selection, a byte sign-extended when it should be zero-extended, or a capture on an idle cycle shows up as a wrong lane value on the next `out_valid` pulse, two cycles after the operation. A lost or duplicated stage-one valid bit changes `out_valid` in that same cycle. Corrupted data held during idle cycles shows up as a change of `out_data` while `out_valid` is low. The bench varies the mode every cycle so that selection faults reach the output quickly.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

   typedef enum logic [1:0] {
      SEL_PACKED_U = 2'd0,
      SEL_SCALAR_U = 2'd1,
      SEL_HIGH_S   = 2'd2,
      SEL_LOW_U    = 2'd3
   } sel_mode_e;

endpackage

// File: rtl/simd_mul_opsel.sv
// Picks, for every lane, the 8-bit value (widened by one bit so that signed
// and unsigned bytes share one multiplier) and the 16-bit multiplier.
module simd_mul_opsel
   import simd_mul_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16
) (
   input  sel_mode_e                          mode,
   input  logic [LANES*WORD_W-1:0]            opa,
   input  logic [LANES*WORD_W-1:0]            opb,
   output logic [LANES-1:0][BYTE_W:0]         mcand,
   output logic [LANES-1:0][WORD_W-1:0]       mplier
);

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      logic [BYTE_W:0]   b_sel;
      logic [WORD_W-1:0] w_sel;

      always_comb begin
         b_sel = {1'b0, opa[n*BYTE_W +: BYTE_W]};
         w_sel = opb[n*WORD_W +: WORD_W];
         case (mode)
            SEL_PACKED_U: ;
            SEL_SCALAR_U: w_sel = opb[WORD_W-1:0];
            SEL_HIGH_S:   b_sel = {opa[n*WORD_W+WORD_W-1],
                                   opa[n*WORD_W+BYTE_W +: BYTE_W]};
            SEL_LOW_U:    b_sel = {1'b0, opa[n*WORD_W +: BYTE_W]};
            default: ;
         endcase
      end

      assign mcand[n]  = b_sel;
      assign mplier[n] = w_sel;
   end

endmodule

// File: rtl/simd_mul_lane.sv
// One lane: signed multiply, add one half of the output LSB, keep the
// WORD_W bits above the fraction. Result register is stage two.
module simd_mul_lane #(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [BYTE_W:0]   mcand,
   input  logic signed [WORD_W-1:0] mplier,
   output logic [WORD_W-1:0]        res
);

   localparam int PROD_W = BYTE_W + 1 + WORD_W;
   localparam logic signed [PROD_W-1:0] HALF =
      {{(PROD_W-BYTE_W){1'b0}}, 1'b1, {(BYTE_W-1){1'b0}}};

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] rounded;
   logic                     unused_bits;

   assign prod        = PROD_W'(mcand) * PROD_W'(mplier);
   assign rounded     = prod + HALF;
   assign unused_bits = ^{rounded[PROD_W-1], rounded[BYTE_W-1:0]};

   always_ff @(posedge clk) begin
      if (rst) begin
         res <= '0;
      end else if (en) begin
         res <= rounded[BYTE_W +: WORD_W];
      end
   end

endmodule

// File: rtl/simd_mul8x16.sv
module simd_mul8x16
   import simd_mul_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [1:0]                in_mode,
   input  logic [LANES*WORD_W-1:0]   in_opa,
   input  logic [LANES*WORD_W-1:0]   in_opb,
   output logic                      out_valid,
   output logic [LANES*WORD_W-1:0]   out_data
);

   if (WORD_W != 2*BYTE_W) begin : g_bad_word
      $error("simd_mul8x16: WORD_W must be twice BYTE_W");
   end
   if (LANES < 1 || BYTE_W < 2) begin : g_bad_shape
      $error("simd_mul8x16: LANES >= 1 and BYTE_W >= 2 required");
   end

   sel_mode_e                     mode_e;
   logic [LANES-1:0][BYTE_W:0]    sel_b;
   logic [LANES-1:0][WORD_W-1:0]  sel_w;
   logic                          s1_valid;
   logic [LANES-1:0][BYTE_W:0]    s1_b;
   logic [LANES-1:0][WORD_W-1:0]  s1_w;

   assign mode_e = sel_mode_e'(in_mode);

   simd_mul_opsel #(
      .LANES (LANES),
      .BYTE_W(BYTE_W),
      .WORD_W(WORD_W)
   ) opsel_i (
      .mode  (mode_e),
      .opa   (in_opa),
      .opb   (in_opb),
      .mcand (sel_b),
      .mplier(sel_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_b     <= '0;
         s1_w     <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_b <= sel_b;
            s1_w <= sel_w;
         end
      end
   end

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      simd_mul_lane #(
         .BYTE_W(BYTE_W),
         .WORD_W(WORD_W)
      ) lane_i (
         .clk   (clk),
         .rst   (rst),
         .en    (s1_valid),
         .mcand (s1_b[n]),
         .mplier(s1_w[n]),
         .res   (out_data[n*WORD_W +: WORD_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= s1_valid;
      end
   end

endmodule

// File: rtl/simd_mul8x16_chk.sv
module simd_mul8x16_chk #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      in_valid,
   input logic [1:0]                in_mode,
   input logic [LANES*WORD_W-1:0]   in_opa,
   input logic [LANES*WORD_W-1:0]   in_opb,
   input logic                      out_valid,
   input logic [LANES*WORD_W-1:0]   out_data
);

   localparam logic [WORD_W-1:0] UNIT = WORD_W'(1 << BYTE_W);

   logic [1:0] since_rst;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= 2'd0;
      end else if (since_rst != 2'd3) begin
         since_rst <= since_rst + 2'd1;
      end
   end

   function automatic logic [LANES*WORD_W-1:0] widen_bytes(
      input logic [LANES*WORD_W-1:0] a);
      logic [LANES*WORD_W-1:0] r;
      r = '0;
      for (int n = 0; n < LANES; n++) begin
         r[n*WORD_W +: WORD_W] = WORD_W'(a[n*BYTE_W +: BYTE_W]);
      end
      return r;
   endfunction

   // R8: valid travels two cycles
   a_r8_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

   // R9: first cycle after reset shows cleared outputs
   a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd0) |-> (!out_valid && out_data == '0));

   // R9: an all-zero multiplier operand gives a zero result
   a_r9_zero_mplier: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd2 && $past(in_valid && in_opb == '0, 2))
      |-> (out_valid && out_data == '0));

   // R10: idle cycles keep the data
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd1 && !out_valid) |-> $stable(out_data));

   // R4: unit scalar returns the bytes zero-extended
   a_r4_unit_scalar: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd2 &&
       $past(in_valid && in_mode == 2'd1 && in_opb[WORD_W-1:0] == UNIT, 2))
      |-> (out_data == widen_bytes($past(in_opa, 2))));

endmodule

bind simd_mul8x16 simd_mul8x16_chk #(
   .LANES (LANES),
   .BYTE_W(BYTE_W),
   .WORD_W(WORD_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_mode  (in_mode),
   .in_opa   (in_opa),
   .in_opb   (in_opb),
   .out_valid(out_valid),
   .out_data (out_data)
);

// File: tb/simd_mul8x16_tb_top.sv
module simd_mul8x16_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  in_mode = 2'd0;
   logic [63:0] in_opa = '0;
   logic [63:0] in_opb = '0;
   logic        out_valid;
   logic [63:0] out_data;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R9";
   bit    started = 1'b0;
   bit    done = 1'b0;

   always #10 clk = ~clk;

   simd_mul8x16 dut_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_mode  (in_mode),
      .in_opa   (in_opa),
      .in_opb   (in_opb),
      .out_valid(out_valid),
      .out_data (out_data)
   );

   function automatic logic [63:0] ref_calc(input logic [1:0] m,
                                            input logic [63:0] a,
                                            input logic [63:0] b);
      logic [63:0] r;
      r = '0;
      for (int n = 0; n < 4; n++) begin
         int x;
         int y;
         int p;
         y = $signed(b[16*n +: 16]);
         case (m)
            2'd0: x = int'(a[8*n +: 8]);
            2'd1: begin
               x = int'(a[8*n +: 8]);
               y = $signed(b[15:0]);
            end
            2'd2: x = $signed(a[16*n+8 +: 8]);
            default: x = int'(a[16*n +: 8]);
         endcase
         p = (x * y + 128) >>> 8;
         r[16*n +: 16] = p[15:0];
      end
      return r;
   endfunction

   // Behavioural model: a queue of in-flight operations.
   bit          qv[$];
   logic [63:0] qd[$];
   logic        exp_v = 1'b0;
   logic [63:0] exp_d = '0;

   always @(posedge clk) begin
      bit          v;
      logic [63:0] d;
      started = 1'b1;
      if (rst) begin
         qv = {1'b0};
         qd = {64'h0};
         exp_v = 1'b0;
         exp_d = '0;
      end else begin
         v = qv.pop_front();
         d = qd.pop_front();
         qv.push_back(in_valid);
         qd.push_back(ref_calc(in_mode, in_opa, in_opb));
         exp_v = v;
         if (v) exp_d = d;
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         checks++;
         if (out_valid !== exp_v || out_data !== exp_d) begin
            errors++;
            $display("FAIL %s: actual valid=%b data=%h expected valid=%b data=%h",
                     cur_req, out_valid, out_data, exp_v, exp_d);
         end
      end
   end

   task automatic drive(input logic v, input logic [1:0] m,
                        input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      in_valid = v;
      in_mode  = m;
      in_opa   = a;
      in_opb   = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, in_mode, in_opa, in_opb);
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R8: watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9: outputs cleared while reset is held
      cur_req = "R9";
      idle(3);
      @(negedge clk);
      rst = 1'b0;

      // R3 + R7: packed unsigned bytes, upper opa garbage
      cur_req = "R3";
      drive(1, 2'd0, 64'hDEAD_BEEF_40FF_0280, 64'h1234_8000_0100_7FFF);
      cur_req = "R7";
      drive(1, 2'd0, 64'h5A5A_A5A5_0102_0304, 64'h0100_0100_0100_0100);
      drive(1, 2'd1, 64'hFFFF_0000_1122_3344, 64'h0000_0000_0000_0200);
      idle(2);

      // R2: rounding edges, m = 1
      cur_req = "R2";
      drive(1, 2'd0, 64'h0000_0000_0101_0101, 64'hFF7F_FF80_007F_0080);
      drive(1, 2'd0, 64'h0000_0000_0303_0303, 64'hFFD5_002B_FFAB_0055);
      idle(2);

      // R4: broadcast scalar, opb upper bits ignored
      cur_req = "R4";
      drive(1, 2'd1, 64'h0000_0000_FF80_017F, 64'hABCD_EF01_2345_0100);
      drive(1, 2'd1, 64'hFFFF_FFFF_FF80_017F, 64'h0000_0000_0000_8000);
      drive(1, 2'd1, 64'h0000_0000_1020_3040, 64'h9999_9999_9999_FFF0);
      idle(2);

      // R5: signed upper byte of each word
      cur_req = "R5";
      drive(1, 2'd2, 64'h80FF_7F11_FE22_0133, 64'h0100_0100_0100_0100);
      drive(1, 2'd2, 64'hC000_4000_80AA_FF55, 64'h7FFF_8000_1234_FEDC);
      idle(2);

      // R6: unsigned lower byte of each word
      cur_req = "R6";
      drive(1, 2'd3, 64'h11FF_2280_337F_4401, 64'h0100_0100_0100_0100);
      drive(1, 2'd3, 64'hAA10_BB20_CC30_DD40, 64'hF000_0FFF_8001_0033);
      idle(2);

      // R11: extremes
      cur_req = "R11";
      drive(1, 2'd3, 64'h00FF_00FF_00FF_00FF, 64'h8000_8000_8000_8000);
      drive(1, 2'd2, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
      drive(1, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF);
      idle(2);

      // R1: four different lanes at once
      cur_req = "R1";
      drive(1, 2'd0, 64'h0000_0000_0C80_7F01, 64'h0001_FFFF_4000_9ABC);
      idle(2);

      // R8: back-to-back operations, mixed modes
      cur_req = "R8";
      for (int i = 0; i < 10; i++) drive(1, 2'(i), rnd64(), rnd64());
      // R10: gaps keep the last result
      cur_req = "R10";
      drive(0, 2'd2, rnd64(), rnd64());
      drive(0, 2'd1, rnd64(), rnd64());
      drive(1, 2'd3, rnd64(), rnd64());
      idle(4);

      // R9: reset with operations in flight, plus zero multipliers
      cur_req = "R9";
      drive(1, 2'd0, rnd64(), rnd64());
      drive(1, 2'd2, rnd64(), 64'h0);
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      drive(1, 2'd3, rnd64(), 64'h0);
      drive(1, 2'd1, rnd64(), 64'hFFFF_FFFF_FFFF_0000);
      idle(3);

      // R1: random traffic
      cur_req = "R1";
      for (int i = 0; i < 400; i++) begin
         drive(1'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)),
               rnd64(), rnd64());
      end
      idle(4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule